// File: doc/BRIEF.md
# I2C SCL Timebase Divider

This block derives the timing base of an I2C master from the system clock. A byte-wide baud setting holds two fields. A 3-bit exponent selects a power-of-two prescaler. A 4-bit linear factor then divides the prescaler output by that factor plus one. The result is a tick at ten times the SCL rate. A phase counter splits each SCL period into ten tick slots. It drives the SCL level and four single-cycle strobes for the byte engine: period start (SCL falls), data drive, SCL rise, and data sample.

The baud setting is written over a plain write-only pair of pins. In a full controller, reads at the same register address return bus status, and that read path lives outside this block. A written value is held as pending. It becomes the active setting only at the next SCL period boundary, so the divider never shortens or stretches a period that is already running. A build option adds one more doubling to the exponent stage.

Top module: `scl_timebase`

## Requirements
- R1: After reset the active setting is 0x44 (N = 4, M = 8) and SCL is high. No strobe is asserted until the first tick. With the default parameters the first full SCL period lasts 1440 clock cycles.
- R2: Setting bits [2:0] are the exponent N and bits [6:3] are the linear factor M. Bit 7 has no effect on timing, but it is kept in the active setting.
- R3: Successive ticks are (M+1) * 2^N clock cycles apart. This spacing is T.
- R4: Successive period-start strobes are 10 * T cycles apart. A period-start strobe always comes one cycle after a tick.
- R5: SCL is low for tick slots 0 to 4 and high for slots 5 to 9. The rise strobe comes 5 * T cycles after the period-start strobe, and SCL is high in that cycle.
- R6: The drive strobe comes 2 * T cycles and the sample strobe 7 * T cycles after the period-start strobe. At most one of the four strobes is high in any cycle.
- R7: A write is adopted at the first period boundary after the write cycle. The active setting changes only in the cycle of a period-start strobe, and the period running during the write keeps its old length.
- R8: If several writes arrive within one period, the last one written is the one adopted.
- R9: With EXTRA_DOUBLE = 1 the tick spacing is (M+1) * 2^(N+1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_we | input | 1 | Write strobe for the baud setting |
| baud_wdata | input | 8 | Baud setting: [2:0] N, [6:3] M, [7] unused |
| active_baud | output | 8 | Setting currently applied to the divider |
| tick | output | 1 | One-cycle pulse at ten times the SCL rate |
| period_start | output | 1 | Strobe at slot 0, where SCL falls |
| drive_stb | output | 1 | Strobe at slot 2, where the data line may change |
| rise_stb | output | 1 | Strobe at slot 5, where SCL rises |
| sample_stb | output | 1 | Strobe at slot 7, where the data line is sampled |
| scl_hi | output | 1 | SCL level: high in slots 5 to 9 |

## Verification
The bench builds two instances from the same write pins. One uses EXTRA_DOUBLE = 0 and the other EXTRA_DOUBLE = 1, and both keep the default ten-slot phase layout and the 0x44 reset setting. The plain instance takes random settings with N limited to 0..3 and any M. This keeps periods to at most 1280 cycles, so many settings fit in the run, and the fastest case (one cycle per tick) is reached. The doubled instance shows the extra exponent step on a directed setting.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int N_W    = 3;
  localparam int M_W    = 4;
  localparam int BAUD_W = 8;

  typedef struct packed {
    logic           spare;
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } baud_t;
endpackage

// File: rtl/scl_baud_hold.sv
module scl_baud_hold
  import scl_div_pkg::*;
#(
  parameter logic [BAUD_W-1:0] RESET_BAUD = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BAUD_W-1:0] wdata,
  input  logic              boundary,
  output logic [BAUD_W-1:0] active,
  output logic [N_W-1:0]    n,
  output logic [M_W-1:0]    m
);
  logic [BAUD_W-1:0] pending;
  baud_t             fields;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= RESET_BAUD;
      active  <= RESET_BAUD;
    end else begin
      if (we)       pending <= wdata;
      if (boundary) active  <= pending;
    end
  end

  assign fields = baud_t'(active);
  assign n      = fields.n;
  assign m      = fields.m;
endmodule

// File: rtl/scl_pow2_prescaler.sv
module scl_pow2_prescaler #(
  parameter int N_W          = 3,
  parameter bit EXTRA_DOUBLE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n,
  output logic           pulse
);
  localparam int MAX_EXP = (1 << N_W) - 1 + (EXTRA_DOUBLE ? 1 : 0);
  localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam int EXP_W   = N_W + 1;

  logic [EXP_W-1:0] expo;
  logic [CNT_W:0]   lim_full;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;

  generate
    if (EXTRA_DOUBLE) begin : g_doubled
      assign expo = {1'b0, n} + EXP_W'(1);
    end else begin : g_plain
      assign expo = {1'b0, n};
    end
  endgenerate

  assign lim_full = ((CNT_W+1)'(1) << expo) - (CNT_W+1)'(1);
  assign lim      = lim_full[CNT_W-1:0];
  assign pulse    = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (pulse) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_linear_stage.sv
module scl_linear_stage #(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [M_W-1:0] m,
  output logic           tick
);
  logic [M_W-1:0] cnt;
  logic           at_end;

  assign at_end = (cnt == m);
  assign tick   = adv && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (adv) cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int TICKS     = 10,
  parameter int LOW_TICKS = 5,
  parameter int DRIVE_AT  = 2,
  parameter int SAMPLE_AT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic boundary,
  output logic start_stb,
  output logic drive_stb,
  output logic rise_stb,
  output logic sample_stb,
  output logic scl_hi
);
  localparam int PH_W = $clog2(TICKS);
  localparam logic [PH_W-1:0] LAST = PH_W'(TICKS - 1);
  localparam logic [PH_W-1:0] RISE = PH_W'(LOW_TICKS);
  localparam logic [PH_W-1:0] DRV  = PH_W'(DRIVE_AT);
  localparam logic [PH_W-1:0] SMP  = PH_W'(SAMPLE_AT);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_nxt;

  assign ph_nxt   = (ph == LAST) ? '0 : ph + 1'b1;
  assign boundary = tick && (ph == LAST);
  assign scl_hi   = (ph >= RISE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= LAST;
      start_stb  <= 1'b0;
      drive_stb  <= 1'b0;
      rise_stb   <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      if (tick) ph <= ph_nxt;
      start_stb  <= tick && (ph_nxt == '0);
      drive_stb  <= tick && (ph_nxt == DRV);
      rise_stb   <= tick && (ph_nxt == RISE);
      sample_stb <= tick && (ph_nxt == SMP);
    end
  end
endmodule

// File: rtl/scl_timebase.sv
module scl_timebase
  import scl_div_pkg::*;
#(
  parameter bit                EXTRA_DOUBLE = 1'b0,
  parameter logic [BAUD_W-1:0] RESET_BAUD   = 8'h44,
  parameter int                TICKS        = 10,
  parameter int                LOW_TICKS    = 5,
  parameter int                DRIVE_AT     = 2,
  parameter int                SAMPLE_AT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_we,
  input  logic [BAUD_W-1:0] baud_wdata,
  output logic [BAUD_W-1:0] active_baud,
  output logic              tick,
  output logic              period_start,
  output logic              drive_stb,
  output logic              rise_stb,
  output logic              sample_stb,
  output logic              scl_hi
);
  logic [N_W-1:0] n_sel;
  logic [M_W-1:0] m_sel;
  logic           pre_pulse;
  logic           boundary;

  scl_baud_hold #(.RESET_BAUD(RESET_BAUD)) u_hold (
    .clk(clk), .rst_n(rst_n), .we(baud_we), .wdata(baud_wdata),
    .boundary(boundary), .active(active_baud), .n(n_sel), .m(m_sel)
  );

  scl_pow2_prescaler #(.N_W(N_W), .EXTRA_DOUBLE(EXTRA_DOUBLE)) u_pre (
    .clk(clk), .rst_n(rst_n), .n(n_sel), .pulse(pre_pulse)
  );

  scl_linear_stage #(.M_W(M_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .adv(pre_pulse), .m(m_sel), .tick(tick)
  );

  scl_phase_seq #(
    .TICKS(TICKS), .LOW_TICKS(LOW_TICKS),
    .DRIVE_AT(DRIVE_AT), .SAMPLE_AT(SAMPLE_AT)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .boundary(boundary),
    .start_stb(period_start), .drive_stb(drive_stb), .rise_stb(rise_stb),
    .sample_stb(sample_stb), .scl_hi(scl_hi)
  );
endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] active_baud,
  input logic       tick,
  input logic       period_start,
  input logic       drive_stb,
  input logic       rise_stb,
  input logic       sample_stb,
  input logic       scl_hi
);
  // R4: a period start always follows a tick
  p_start_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> $past(tick));

  // R5: SCL is high at the rise strobe and low at the period start
  p_rise_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> scl_hi);
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> !scl_hi);
  p_rose_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hi) |-> rise_stb);

  // R6: strobes never overlap
  p_stb_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({period_start, drive_stb, rise_stb, sample_stb}));

  // R7: the active setting only moves on a period boundary
  p_adopt_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_baud != $past(active_baud)) |-> period_start);
endmodule

bind scl_timebase scl_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active_baud(active_baud), .tick(tick),
  .period_start(period_start), .drive_stb(drive_stb), .rise_stb(rise_stb),
  .sample_stb(sample_stb), .scl_hi(scl_hi)
);

// File: tb/test_scl_timebase.sv
module test_scl_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;

  logic [7:0] act_a, act_x;
  logic tick_a, start_a, drv_a, rise_a, smp_a, hi_a;
  logic tick_x, start_x, drv_x, rise_x, smp_x, hi_x;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  logic [7:0] cur_a = 8'h44;
  longint last_start = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_timebase #(.EXTRA_DOUBLE(1'b0)) i_scl_timebase (
    .clk(clk), .rst_n(rst_n), .baud_we(we), .baud_wdata(wd),
    .active_baud(act_a), .tick(tick_a), .period_start(start_a),
    .drive_stb(drv_a), .rise_stb(rise_a), .sample_stb(smp_a), .scl_hi(hi_a)
  );

  scl_timebase #(.EXTRA_DOUBLE(1'b1)) i_scl_timebase_x (
    .clk(clk), .rst_n(rst_n), .baud_we(we), .baud_wdata(wd),
    .active_baud(act_x), .tick(tick_x), .period_start(start_x),
    .drive_stb(drv_x), .rise_stb(rise_x), .sample_stb(smp_x), .scl_hi(hi_x)
  );

  function automatic longint tspan(input logic [7:0] b, input int extra);
    return longint'(b[6:3] + 1) << (b[2:0] + extra);
  endfunction

  function automatic bit sel(input int which);
    case (which)
      0: return start_a;
      1: return drv_a;
      2: return rise_a;
      3: return smp_a;
      4: return start_x;
      default: return tick_a;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sig(input int which, output longint t);
    do @(negedge clk); while (!sel(which));
    t = cyc;
  endtask

  task automatic write_baud(input logic [7:0] b);
    @(negedge clk);
    we = 1'b1; wd = b;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Caller sits on the negedge of a period start of instance a.
  task automatic run_setting(input logic [7:0] b);
    longint t0, t1, ta, tb, tp;
    longint told, tnew;
    told = tspan(cur_a, 0);
    tnew = tspan(b, 0);
    tp   = last_start;
    write_baud(b);
    chk(act_a == cur_a, "R7 held before boundary", act_a, cur_a);
    wait_sig(0, t0);
    chk(t0 - tp == 10 * told, "R7 running period keeps old length", t0 - tp, 10 * told);
    chk(act_a == b, "R7 adopted at boundary", act_a, b);
    cur_a = b;
    wait_sig(1, t1);
    chk(t1 - t0 == 2 * tnew, "R6 drive at slot 2", t1 - t0, 2 * tnew);
    chk(hi_a == 1'b0, "R5 low at drive", hi_a, 0);
    wait_sig(2, t1);
    chk(t1 - t0 == 5 * tnew, "R5 rise at slot 5", t1 - t0, 5 * tnew);
    chk(hi_a == 1'b1, "R5 high at rise", hi_a, 1);
    wait_sig(3, t1);
    chk(t1 - t0 == 7 * tnew, "R6 sample at slot 7", t1 - t0, 7 * tnew);
    wait_sig(0, t1);
    chk(t1 - t0 == 10 * tnew, "R4 period length (R2 decode)", t1 - t0, 10 * tnew);
    wait_sig(5, ta);
    wait_sig(5, tb);
    chk(tb - ta == tnew, "R3 tick spacing", tb - ta, tnew);
    wait_sig(0, last_start);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    longint t0, t1;
    logic [7:0] b;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    chk(act_a == 8'h44, "R1 reset setting", act_a, 8'h44);
    chk(hi_a == 1'b1, "R1 SCL high in reset", hi_a, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({start_a, drv_a, rise_a, smp_a} == 4'b0, "R1 no strobes after reset",
        {start_a, drv_a, rise_a, smp_a}, 0);
    wait_sig(0, t0);
    wait_sig(0, t1);
    chk(t1 - t0 == 1440, "R1 default period", t1 - t0, 1440);
    last_start = t1;

    // directed fastest case and bit-7 variant
    run_setting(8'h00);
    run_setting(8'hF8 & 8'hFB);
    run_setting(8'h8A);
    // random settings, N limited to 0..3
    for (int i = 0; i < 8; i++) begin
      b = 8'($urandom);
      b[2] = 1'b0;
      run_setting(b);
    end

    // R8: two writes in one period, the last one wins
    write_baud(8'h11);
    write_baud(8'h0B);
    wait_sig(0, t0);
    chk(act_a == 8'h0B, "R8 last write adopted", act_a, 8'h0B);
    wait_sig(0, t1);
    chk(t1 - t0 == 10 * tspan(8'h0B, 0), "R8 period from last write",
        t1 - t0, 10 * tspan(8'h0B, 0));
    cur_a = 8'h0B;

    // R9: doubled exponent instance, N=2 M=1
    write_baud(8'h0A);
    wait_sig(4, t0);
    wait_sig(4, t0);
    wait_sig(4, t1);
    chk(t1 - t0 == 10 * tspan(8'h0A, 1), "R9 doubled period", t1 - t0, 10 * tspan(8'h0A, 1));
    chk(act_x == 8'h0A, "R9 doubled instance setting", act_x, 8'h0A);
    finish_up();
  end
endmodule